// File: doc/BRIEF.md
# Receive Alarm and Shutdown Controller

This block watches the recovered receive stream of a line interface and raises two active-low alarms: one for a lost signal and one for a lost receive clock. A run-length counter tracks back-to-back zero bits in the recovered data. Its verdict is merged with a flag from an external analog amplitude detector. When the local analog loopback is enabled, the analog flag is left out of the merge. A clock watchdog in the reference clock domain tracks whether the recovered clock is still toggling.

The block also gates the receive outputs toward the terminal side. With shutdown enabled and the signal lost, the outputs are silenced in the way that suits the selected rail mode. With shutdown disabled, the outputs keep following the receive path even while the signal is lost. An alarm-test input drives both alarms to their active level and leaves the data outputs as they are. Because both alarms are active-low, a board can tie them together into a single alarm line.

Top module: `los_alarm_ctrl`

## Requirements
- R1: A bit counts as a one when `rx_p` or `rx_n` is high at a rising edge of `rx_clk`, and as a zero otherwise. `los_n` goes low once more than ZERO_LIMIT (128) zeros have arrived in a row. It stays high after exactly 128 zeros.
- R2: The first one received after a zero run ends the digital loss indication, and `los_n` returns high unless the analog flag holds it low.
- R3: When `lpbk_local_n` is 1, `los_n` is low whenever `analog_los` is 1. When `lpbk_local_n` is 0, `analog_los` has no effect on `los_n`.
- R4: In single-rail mode (`dual_mode`=0), with `shutdown`=1 and loss of signal present, `rx_clk_o`=1, `rx_p_o`=1 and `loc_n`=0.
- R5: In dual-rail mode (`dual_mode`=1), with `shutdown`=1 and loss of signal present, `rx_p_o`=0, `rx_n_o`=0 and `loc_n`=0. `rx_clk_o` keeps following `rx_clk`.
- R6: With `shutdown`=0 and loss of signal present, `loc_n` stays 1 and the receive outputs keep following their inputs.
- R7: With `alarm_test_n`=0, `los_n`=0 and `loc_n`=0 whatever the other inputs are, and the receive outputs are unchanged.
- R8: The reference clock is divided into windows of WIN_CYC (4) cycles. A window that sees no synchronized rising edge of `rx_clk` counts as missing. Two missing windows in a row drive `loc_n` low. A gap of 3 cycles never does this, and a gap of 20 cycles always does.
- R9: Once `rx_clk` toggles again, `loc_n` returns high within two windows plus the synchronizer delay.
- R10: In single-rail mode with no shutdown forcing, `rx_p_o` = NOT `rx_p` (active-low data), `rx_n_o`=0 and `rx_clk_o`=`rx_clk`. In dual-rail mode, `rx_p_o`=`rx_p` and `rx_n_o`=`rx_n`.
- R11: After reset, with the clock toggling and `analog_los`=0, `los_n`=1 and `loc_n`=1.
- R12: The zero counter saturates instead of wrapping, so a run of 329 zeros still holds `los_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, independent of the receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_clk | input | 1 | Recovered receive clock, asynchronous to `clk` |
| rx_p | input | 1 | Recovered positive rail, or the single-rail data |
| rx_n | input | 1 | Recovered negative rail |
| dual_mode | input | 1 | 1 selects the dual-rail output format |
| analog_los | input | 1 | Analog detector flag, 1 means the amplitude is too low |
| lpbk_local_n | input | 1 | Active-low local analog loopback enable |
| shutdown | input | 1 | 1 silences the receive outputs on loss of signal |
| alarm_test_n | input | 1 | Active-low alarm test |
| los_n | output | 1 | Active-low loss-of-signal alarm |
| loc_n | output | 1 | Active-low loss-of-clock alarm |
| rx_clk_o | output | 1 | Receive clock toward the terminal side |
| rx_p_o | output | 1 | Inverted data (single-rail) or positive rail (dual-rail) |
| rx_n_o | output | 1 | Negative rail in dual-rail mode, 0 in single-rail mode |

## Verification
A vector table covers the combinations of rail mode, shutdown, analog flag, loopback and alarm test. This separates the real loss merge, the gating for each rail mode and the forced alarms, which can all drive an output low. The zero-run patterns sit on both sides of the threshold (128 and 129 zeros) and include a run long enough to catch a counter that wraps. A single one then shows whether the run ends correctly. Gaps in the recovered clock of 3 and 20 cycles, followed by restarting the clock, separate a watchdog that trips too early or never clears from one that follows the two-window rule.

// File: rtl/los_alarm_pkg.sv
package los_alarm_pkg;

    // receive-side signals after gating
    typedef struct packed {
        logic clk;
        logic pos;
        logic neg;
    } rx_out_t;

    // alarm set, active-high internally
    typedef struct packed {
        logic sig_lost;
        logic clk_lost;
    } alarm_t;

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_clk,
    input  logic async_bit,
    output logic edge_pulse,
    output logic edge_bit
);
    typedef struct packed {
        logic [STAGES:0]   clk_sr;
        logic [STAGES-1:0] bit_sr;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.clk_sr[0] = async_clk;
        st_d.bit_sr[0] = async_bit;
        for (int i = 1; i <= STAGES; i++) begin
            st_d.clk_sr[i] = st_q.clk_sr[i-1];
        end
        for (int i = 1; i < STAGES; i++) begin
            st_d.bit_sr[i] = st_q.bit_sr[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_pulse = st_q.clk_sr[STAGES-1] & ~st_q.clk_sr[STAGES];
    assign edge_bit   = st_q.bit_sr[STAGES-1];
endmodule

// File: rtl/zero_run_det.sv
module zero_run_det #(
    parameter int ZERO_LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_one,
    output logic run_lost
);
    localparam int CNT_W = $clog2(ZERO_LIMIT + 2);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(ZERO_LIMIT + 1);

    typedef struct packed {
        logic [CNT_W-1:0] zcnt;
    } zr_t;

    zr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_valid) begin
            if (bit_one)             st_d.zcnt = '0;
            else if (st_q.zcnt != SAT) st_d.zcnt = st_q.zcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_lost = (st_q.zcnt == SAT);
endmodule

// File: rtl/clk_watch.sv
module clk_watch #(
    parameter int WIN_CYC      = 4,
    parameter int MISS_WINDOWS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_pulse,
    output logic clk_lost
);
    localparam int WIN_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
    localparam int MISS_W = $clog2(MISS_WINDOWS + 1);
    localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic [MISS_W-1:0] MISS_SAT = MISS_W'(MISS_WINDOWS);

    typedef struct packed {
        logic [WIN_W-1:0]  win;
        logic              seen;
        logic [MISS_W-1:0] miss;
    } cw_t;

    cw_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.win == WIN_LAST) begin
            st_d.win  = '0;
            st_d.seen = 1'b0;
            if (st_q.seen || edge_pulse)  st_d.miss = '0;
            else if (st_q.miss != MISS_SAT) st_d.miss = st_q.miss + 1'b1;
        end else begin
            st_d.win  = st_q.win + 1'b1;
            st_d.seen = st_q.seen | edge_pulse;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_lost = (st_q.miss == MISS_SAT);
endmodule

// File: rtl/rx_out_gate.sv
module rx_out_gate
    import los_alarm_pkg::*;
(
    input  logic    dual_mode,
    input  logic    shutdown,
    input  logic    alarm_test_n,
    input  alarm_t  raw,
    input  rx_out_t rx_in,
    output rx_out_t rx_out,
    output logic    los_n,
    output logic    loc_n
);
    logic silence;

    always_comb begin
        silence = shutdown & raw.sig_lost;
        if (dual_mode) begin
            rx_out.clk = rx_in.clk;
            rx_out.pos = silence ? 1'b0 : rx_in.pos;
            rx_out.neg = silence ? 1'b0 : rx_in.neg;
        end else begin
            rx_out.clk = silence ? 1'b1 : rx_in.clk;
            rx_out.pos = silence ? 1'b1 : ~rx_in.pos;
            rx_out.neg = 1'b0;
        end
        los_n = ~(raw.sig_lost | ~alarm_test_n);
        loc_n = ~(raw.clk_lost | silence | ~alarm_test_n);
    end
endmodule

// File: rtl/los_alarm_ctrl.sv
module los_alarm_ctrl
    import los_alarm_pkg::*;
#(
    parameter int ZERO_LIMIT   = 128,
    parameter int WIN_CYC      = 4,
    parameter int MISS_WINDOWS = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_clk,
    input  logic rx_p,
    input  logic rx_n,
    input  logic dual_mode,
    input  logic analog_los,
    input  logic lpbk_local_n,
    input  logic shutdown,
    input  logic alarm_test_n,
    output logic los_n,
    output logic loc_n,
    output logic rx_clk_o,
    output logic rx_p_o,
    output logic rx_n_o
);
    logic    edge_pulse, edge_bit, run_lost, clk_lost;
    alarm_t  raw;
    rx_out_t rx_in, rx_out;

    rx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_clk(rx_clk), .async_bit(rx_p | rx_n),
        .edge_pulse(edge_pulse), .edge_bit(edge_bit)
    );

    zero_run_det #(.ZERO_LIMIT(ZERO_LIMIT)) u_zrun (
        .clk(clk), .rst_n(rst_n), .bit_valid(edge_pulse), .bit_one(edge_bit),
        .run_lost(run_lost)
    );

    clk_watch #(.WIN_CYC(WIN_CYC), .MISS_WINDOWS(MISS_WINDOWS)) u_cwatch (
        .clk(clk), .rst_n(rst_n), .edge_pulse(edge_pulse), .clk_lost(clk_lost)
    );

    always_comb begin
        raw.sig_lost = run_lost | (analog_los & lpbk_local_n);
        raw.clk_lost = clk_lost;
        rx_in.clk    = rx_clk;
        rx_in.pos    = rx_p;
        rx_in.neg    = rx_n;
    end

    rx_out_gate u_gate (
        .dual_mode(dual_mode), .shutdown(shutdown), .alarm_test_n(alarm_test_n),
        .raw(raw), .rx_in(rx_in), .rx_out(rx_out), .los_n(los_n), .loc_n(loc_n)
    );

    assign rx_clk_o = rx_out.clk;
    assign rx_p_o   = rx_out.pos;
    assign rx_n_o   = rx_out.neg;
endmodule

// File: rtl/los_alarm_ctrl_chk.sv
module los_alarm_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_clk,
    input logic rx_p,
    input logic rx_n,
    input logic dual_mode,
    input logic analog_los,
    input logic lpbk_local_n,
    input logic shutdown,
    input logic alarm_test_n,
    input logic los_n,
    input logic loc_n,
    input logic rx_clk_o,
    input logic rx_p_o,
    input logic rx_n_o
);
    AST_TEST_FORCES_ALARMS: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_test_n |-> (!los_n && !loc_n)); // R7

    AST_ANALOG_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
        (analog_los && lpbk_local_n) |-> !los_n); // R3

    AST_SHDN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_test_n && !los_n && shutdown && !dual_mode) |-> (rx_clk_o && rx_p_o && !loc_n)); // R4

    AST_SHDN_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_test_n && !los_n && shutdown && dual_mode) |-> (!rx_p_o && !rx_n_o && !loc_n)); // R5

    AST_SINGLE_NEG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_mode |-> !rx_n_o); // R10

    AST_NO_SHDN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown && dual_mode) |-> (rx_p_o == rx_p && rx_n_o == rx_n && rx_clk_o == rx_clk)); // R6
endmodule

bind los_alarm_ctrl los_alarm_ctrl_chk u_chk (.*);

// File: tb/los_alarm_ctrl_bench.sv
module los_alarm_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_clk = 1'b0, rx_p = 1'b0, rx_n = 1'b0;
    logic dual_mode = 1'b0, analog_los = 1'b0, lpbk_local_n = 1'b1;
    logic shutdown = 1'b0, alarm_test_n = 1'b1;
    logic los_n, loc_n, rx_clk_o, rx_p_o, rx_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    los_alarm_ctrl u_los_alarm_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_p(rx_p), .rx_n(rx_n),
        .dual_mode(dual_mode), .analog_los(analog_los), .lpbk_local_n(lpbk_local_n),
        .shutdown(shutdown), .alarm_test_n(alarm_test_n),
        .los_n(los_n), .loc_n(loc_n), .rx_clk_o(rx_clk_o), .rx_p_o(rx_p_o), .rx_n_o(rx_n_o)
    );

    // {req[4:0], dual, sd, analog, lpbk_n, test_n, rclk, rp, rn, exp{los_n,loc_n,clk_o,p_o,n_o}}
    localparam logic [17:0] VEC [10] = '{
        {5'd10, 8'b0_0_0_1_1_1_1_0, 5'b11100},  // R10 single, data inverted
        {5'd10, 8'b0_0_0_1_1_0_0_0, 5'b11010},  // R10 single, zero -> high
        {5'd10, 8'b1_0_0_1_1_1_1_0, 5'b11110},  // R10 dual positive rail
        {5'd10, 8'b1_0_0_1_1_0_0_1, 5'b11001},  // R10 dual negative rail
        {5'd6,  8'b0_0_1_1_1_1_1_0, 5'b01100},  // R6 loss without shutdown
        {5'd4,  8'b0_1_1_1_1_0_1_0, 5'b00110},  // R4 single shutdown
        {5'd5,  8'b1_1_1_1_1_1_1_1, 5'b00100},  // R5 dual shutdown
        {5'd3,  8'b0_1_1_0_1_0_1_0, 5'b11000},  // R3 loopback masks analog
        {5'd7,  8'b0_0_0_1_0_1_1_0, 5'b00100},  // R7 alarm test single
        {5'd7,  8'b1_1_0_1_0_1_0_1, 5'b00101}   // R7 alarm test dual
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_p = b; rx_n = 1'b0; rx_clk = 1'b1;
        @(negedge clk);
        rx_clk = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_default();
        @(negedge clk);
        dual_mode = 1'b0; shutdown = 1'b0; analog_los = 1'b0;
        lpbk_local_n = 1'b1; alarm_test_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(5);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        #2;
        check("R11", "los_n after reset", los_n, 1'b1);
        check("R11", "loc_n after reset", loc_n, 1'b1);
        send_bit(1'b1); send_bit(1'b1);

        // vector table
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            {dual_mode, shutdown, analog_los, lpbk_local_n, alarm_test_n, rx_clk, rx_p, rx_n} = VEC[i][12:5];
            #2;
            check($sformatf("R%0d", VEC[i][17:13]), $sformatf("vec%0d los_n", i), los_n, VEC[i][4]);
            check($sformatf("R%0d", VEC[i][17:13]), $sformatf("vec%0d loc_n", i), loc_n, VEC[i][3]);
            check($sformatf("R%0d", VEC[i][17:13]), $sformatf("vec%0d rx_clk_o", i), rx_clk_o, VEC[i][2]);
            check($sformatf("R%0d", VEC[i][17:13]), $sformatf("vec%0d rx_p_o", i), rx_p_o, VEC[i][1]);
            check($sformatf("R%0d", VEC[i][17:13]), $sformatf("vec%0d rx_n_o", i), rx_n_o, VEC[i][0]);
            send_bit(1'b1);
            send_bit(1'b1);
        end
        set_default();
        send_bit(1'b1); send_bit(1'b1);

        // R1: threshold of the zero run
        for (int i = 0; i < 128; i++) send_bit(1'b0);
        idle(4); #2;
        check("R1", "los_n after 128 zeros", los_n, 1'b1);
        send_bit(1'b0);
        idle(4); #2;
        check("R1", "los_n after 129 zeros", los_n, 1'b0);

        // R12: no wrap on a long run
        for (int i = 0; i < 200; i++) send_bit(1'b0);
        idle(4); #2;
        check("R12", "los_n after 329 zeros", los_n, 1'b0);

        // R2: one ends the run
        send_bit(1'b1);
        idle(4); #2;
        check("R2", "los_n after a one", los_n, 1'b1);

        // R4 via the digital detector
        @(negedge clk) shutdown = 1'b1;
        for (int i = 0; i < 129; i++) send_bit(1'b0);
        idle(4); #2;
        check("R4", "loc_n on shutdown loss", loc_n, 1'b0);
        check("R4", "rx_clk_o forced", rx_clk_o, 1'b1);
        check("R4", "rx_p_o forced", rx_p_o, 1'b1);
        send_bit(1'b1);
        idle(4); #2;
        check("R2", "loc_n released after one", loc_n, 1'b1);
        set_default();
        send_bit(1'b1); send_bit(1'b1);

        // R8 / R9: recovered clock watchdog
        idle(3); #2;
        check("R8", "loc_n after 3 idle cycles", loc_n, 1'b1);
        idle(20); #2;
        check("R8", "loc_n after 23 idle cycles", loc_n, 1'b0);
        check("R8", "los_n unaffected by clock gap", los_n, 1'b1);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        #2;
        check("R9", "loc_n after clock returns", loc_n, 1'b1);

        finish_run();
    end
endmodule